// File: doc/BRIEF.md
# Interrupt Status Enable Controller

This block collects hardware event pulses from a host controller into a bank of pending flags. It holds a mask of enabled sources and drives a single interrupt line toward the processor. Software sees it through three 32-bit word registers on a plain single-cycle register bus. The pending register is cleared by writing ones to it. The enable mask is changed through two separate addresses: one sets bits and the other clears them. Both of those addresses read back the same mask.

Eight sources are implemented, at fixed bit positions. Bits 0 to 6 carry, in order of position, scheduling overrun, done-queue writeback, frame start, resume detection, fatal error, frame-counter wrap and hub port change. Bit 30 carries handover of control. Bit 31 of the enable mask is a master switch that gates every source. The events themselves are produced elsewhere. This block only captures them, keeps the registers and forms the interrupt line.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is low and after it is released, the pending register, the enable mask and `irq_o` are all 0.
- R2: A 1 on `hw_evt_i` at an implemented position (bits 0 to 6 and bit 30) sets that pending bit at the next rising clock edge. The bit stays set until software clears it.
- R3: A write to address 0 (pending register) clears every implemented pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A write to address 1 (enable-set) sets every implemented enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: A write to address 2 (enable-clear) clears every implemented enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: Reads of address 1 and address 2 both return the current enable mask. Reads of address 0 return the pending register. Reads of address 3 return 0. Read data is combinational from the address.
- R7: When an event and a software clear hit the same pending bit in the same cycle, the bit is set after that edge. Other bits cleared by the same write do clear.
- R8: `irq_o` is 1 exactly when enable bit 31 (master) is 1 and at least one of bits 0 to 30 is both pending and enabled. It follows register state with no further delay.
- R9: Unimplemented bits read as 0 in both registers and ignore events and writes. In the enable mask, bits 0 to 6, 30 and 31 are implemented. In the pending register, bits 0 to 6 and 30 are implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| hw_evt_i | input | 32 | One-cycle event pulses, one bit per source position |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 2 | Word address: 0 pending, 1 enable-set, 2 enable-clear |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can land in the same cycle are hardware capture of an event and a software write-one-to-clear on the same pending bit. The bench first makes bits 1 and 4 pending. In a single cycle it then pulses event bit 4 and writes ones to bits 1 and 4 of the pending register. Reading the register afterwards must show bit 4 still set and bit 1 cleared. That shows the event wins only on its own bit and does not block the clear of the others.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;

  // word addresses on the register bus
  localparam int unsigned ADR_PENDING = 0;
  localparam int unsigned ADR_EN_SET  = 1;
  localparam int unsigned ADR_EN_CLR  = 2;

  // implemented source positions and master switch position
  localparam logic [REG_W-1:0] SRC_MASK_DEF   = 32'h4000_007F;
  localparam int unsigned      MASTER_POS_DEF = 31;

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic bit_q;
      logic bit_nxt;
      logic bit_upd;

      // hardware event has priority over the software clear
      always_comb begin
        bit_upd = evt_i[i] | (clr_en_i & clr_data_i[i]);
        bit_nxt = bit_q;
        if (clr_en_i && clr_data_i[i]) bit_nxt = 1'b0;
        if (evt_i[i])                  bit_nxt = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_upd) begin
          bit_q <= bit_nxt;
        end
      end

      assign q_o[i] = bit_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic bit_q;
      logic bit_nxt;
      logic bit_upd;

      always_comb begin
        bit_upd = (set_en_i | clr_en_i) & data_i[i];
        bit_nxt = bit_q;
        if (set_en_i && data_i[i]) bit_nxt = 1'b1;
        if (clr_en_i && data_i[i]) bit_nxt = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_upd) begin
          bit_q <= bit_nxt;
        end
      end

      assign q_o[i] = bit_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned  W          = 32,
  parameter logic [W-1:0] SRC_MASK   = '0,
  parameter int unsigned  MASTER_POS = 31
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);

  logic [W-1:0] hit;

  always_comb begin
    hit   = pend_i & en_i & SRC_MASK;
    irq_o = en_i[MASTER_POS] & (|hit);
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      pend_i,
  input  logic [W-1:0]      en_i,
  output logic [W-1:0]      rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(irq_ctrl_pkg::ADR_PENDING)) rdata_o = pend_i;
    if (addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_SET))  rdata_o = en_i;
    if (addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_CLR))  rdata_o = en_i;
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned       DATA_W     = irq_ctrl_pkg::REG_W,
  parameter int unsigned       ADDR_W     = irq_ctrl_pkg::ADDR_W,
  parameter logic [DATA_W-1:0] SRC_MASK   = irq_ctrl_pkg::SRC_MASK_DEF,
  parameter int unsigned       MASTER_POS = irq_ctrl_pkg::MASTER_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] hw_evt_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] MASTER_BIT = DATA_W'(1) << MASTER_POS;
  localparam logic [DATA_W-1:0] EN_MASK    = SRC_MASK | MASTER_BIT;

  logic              wr_pend;
  logic              wr_set;
  logic              wr_clr;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] en_q;

  always_comb begin
    wr_pend = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_PENDING));
    wr_set  = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_SET));
    wr_clr  = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_CLR));
  end

  irq_pending_reg #(
    .W    (DATA_W),
    .MASK (SRC_MASK)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (hw_evt_i),
    .clr_en_i   (wr_pend),
    .clr_data_i (bus_wdata_i),
    .q_o        (stat_q)
  );

  irq_enable_reg #(
    .W    (DATA_W),
    .MASK (EN_MASK)
  ) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (wr_set),
    .clr_en_i (wr_clr),
    .data_i   (bus_wdata_i),
    .q_o      (en_q)
  );

  irq_combine #(
    .W          (DATA_W),
    .SRC_MASK   (SRC_MASK),
    .MASTER_POS (MASTER_POS)
  ) u_comb (
    .pend_i (stat_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  irq_read_mux #(
    .W      (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_rd (
    .addr_i  (bus_addr_i),
    .pend_i  (stat_q),
    .en_i    (en_q),
    .rdata_o (bus_rdata_o)
  );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       ADDR_W     = 2,
  parameter logic [DATA_W-1:0] SRC_MASK   = '0,
  parameter int unsigned       MASTER_POS = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] hw_evt_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq_o
);

  localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << MASTER_POS);

  logic [DATA_W-1:0] evt_m;
  logic              wr_p;
  logic              wr_s;
  logic              wr_c;

  always_comb begin
    evt_m = hw_evt_i & SRC_MASK;
    wr_p  = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_PENDING));
    wr_s  = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_SET));
    wr_c  = bus_wr_i && (bus_addr_i == ADDR_W'(irq_ctrl_pkg::ADR_EN_CLR));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (stat_q == '0 && en_q == '0 && !irq_o); // R1
    end
  end

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_m) |=> ((stat_q & $past(evt_m)) == $past(evt_m))); // R2

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_p && ((bus_wdata_i & evt_m) == '0)) |=> ((stat_q & $past(bus_wdata_i)) == '0)); // R3

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |=> ((en_q & $past(bus_wdata_i & EN_MASK)) == $past(bus_wdata_i & EN_MASK))); // R4

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> ((en_q & $past(bus_wdata_i)) == '0)); // R5

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_p && ((bus_wdata_i & evt_m) != '0)) |=> ((stat_q & $past(bus_wdata_i & evt_m)) != '0)); // R7

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[MASTER_POS] |-> !irq_o); // R8

  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |-> !irq_o); // R8

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~SRC_MASK) == '0) && ((en_q & ~EN_MASK) == '0)); // R9

endmodule

bind irq_status_ctrl irq_status_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .SRC_MASK   (SRC_MASK),
  .MASTER_POS (MASTER_POS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_evt_i    (hw_evt_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .irq_o       (irq_o)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;

  logic        clk;
  logic        rst_n;
  logic [31:0] hw_evt_i;
  logic        bus_wr_i;
  logic [1:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks;
  int failures;
  int cyc;
  bit done;

  irq_status_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_evt_i    (hw_evt_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i    = 1'b1;
    bus_addr_i  = a;
    bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i    = 1'b0;
    bus_wdata_i = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    hw_evt_i = e;
    @(negedge clk);
    hw_evt_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d); chk("R1 pending after reset", d, 32'h0);
    bus_read(2'd1, d); chk("R1 enable after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(32'h0000_0004);
    bus_read(2'd0, d); chk("R2 single event", d, 32'h0000_0004);
    pulse(32'hFFFF_FFFF);
    bus_read(2'd0, d); chk("R2 R9 all events captured, unimplemented 0", d, 32'h4000_007F);
    chk("R8 no irq with mask empty", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_pend_clear();
    logic [31:0] d;
    bus_write(2'd0, 32'h8000_0005);
    bus_read(2'd0, d); chk("R3 write-one clears bits 0 and 2", d, 32'h4000_007A);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d); chk("R3 write-zero keeps pending", d, 32'h4000_007A);
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, d); chk("R3 clear all", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_write(2'd1, 32'h0000_0003);
    bus_read(2'd1, d); chk("R4 set bits 0 1", d, 32'h0000_0003);
    bus_read(2'd2, d); chk("R6 clear address reads same mask", d, 32'h0000_0003);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, d); chk("R4 set with zero keeps mask", d, 32'h0000_0003);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, d); chk("R9 R4 only implemented enable bits set", d, 32'hC000_007F);
    bus_write(2'd2, 32'h4000_0001);
    bus_read(2'd2, d); chk("R5 clear bits 0 and 30", d, 32'h8000_007E);
    bus_write(2'd2, 32'h0);
    bus_read(2'd1, d); chk("R5 clear with zero keeps mask", d, 32'h8000_007E);
    bus_read(2'd3, d); chk("R6 address 3 reads zero", d, 32'h0);
  endtask

  task automatic t_irq();
    // mask now 8000_007E: master on, bit 0 disabled
    chk("R8 idle irq low", {31'b0, irq_o}, 32'h0);
    pulse(32'h0000_0001);
    chk("R8 disabled source gives no irq", {31'b0, irq_o}, 32'h0);
    pulse(32'h0000_0004);
    chk("R8 enabled source raises irq", {31'b0, irq_o}, 32'h1);
    bus_write(2'd2, 32'h8000_0000);
    chk("R8 master off drops irq", {31'b0, irq_o}, 32'h0);
    bus_write(2'd1, 32'h8000_0000);
    chk("R8 master back on raises irq", {31'b0, irq_o}, 32'h1);
    bus_write(2'd0, 32'h0000_0004);
    chk("R8 only disabled bit left pending", {31'b0, irq_o}, 32'h0);
    bus_write(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(32'h0000_0012);
    @(negedge clk);
    hw_evt_i    = 32'h0000_0010;
    bus_wr_i    = 1'b1;
    bus_addr_i  = 2'd0;
    bus_wdata_i = 32'h0000_0012;
    @(negedge clk);
    hw_evt_i    = '0;
    bus_wr_i    = 1'b0;
    bus_wdata_i = '0;
    bus_read(2'd0, d); chk("R7 event beats clear on bit 4, bit 1 cleared", d, 32'h0000_0010);
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; hw_evt_i = '0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_pend_clear();
    t_enable();
    t_irq();
    t_collide();
    do_reset();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule